// File: doc/BRIEF.md
# Packet Transmit Buffer Sequencer

This block sends one radio packet at a time from a 16-byte ring of payload bytes. A host loads the packet length, writes payload bytes into the ring, and sets a start bit. The block then sends a byte stream to a downstream serializer over a valid/ready handshake. The stream is a fixed start marker byte, the length byte, the payload bytes, and, when the `crc_en` input is high at start, a 16-bit checksum.

The ring is smaller than the largest packet, so packets longer than 16 bytes are served while the host keeps writing bytes during transmission. Two faults raise their own flags: a ring that is empty just after the length byte, and a ring that runs dry partway through the payload. Both faults end the packet early. If start is set again without a clear, the previous packet is sent a second time.

Interrupt status flags sit behind six enable bits. They drive one interrupt line. Reading the status clears the flags.

Top module: `pkt_tx_seq`

## Requirements
- R1: After reset the length register reads 0x00, the control register reads 0x03, `irq` is low and `tx_valid` is low.
- R2: The host port uses four addresses: 0 is the length register, 1 is the control register, 2 writes payload, and 3 reads status. A packet is sent as the marker 0xA5, then the length byte, then the payload bytes in the order they were written.
- R3: When `crc_en` is high at start, two checksum bytes follow the payload, high byte first. The checksum uses polynomial 0x1021, MSB first, with seed 0x0000, and covers the length byte and the payload.
- R4: A length of zero sends only the marker and the length byte, plus the checksum when enabled.
- R5: Writing 1 to control bit 7 while idle starts a packet, and writing 0 to it has no effect. Bit 7 reads 1 while the packet is in progress and clears by itself at the end. A packet that ends normally sets status bit 1 (complete).
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R7: A packet of up to 40 bytes is sent correctly while the host refills the ring during transmission. A length write above 40 stores 40.
- R8: If the length is nonzero and the ring is empty when the length byte is accepted, status bit 2 (buffer error) is set. The packet ends after the length byte, start clears, and complete is not set.
- R9: If the ring runs empty after at least one payload byte, status bit 0 (transmit error) is set. The packet ends, start clears, and complete is not set.
- R10: Writing 1 to control bit 6 while idle empties the ring, and writing 0 to it leaves the ring unchanged.
- R11: Setting start while the ring holds no unsent bytes, with no clear since the previous packet and a previous packet of 16 bytes or fewer, sends the previous payload again.
- R12: Control bits 5..0 are the enables for status bits 5..0. A write setting either bit 1 or bit 0 sets both. `irq` is the OR of each status bit ANDed with its enable.
- R13: Status bits 5, 4 and 3 are set while the ring holds fewer than 16 bytes, at most 8 bytes, and no bytes, respectively. Every status bit is cleared by a status read unless its condition still holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe (a status read clears flags) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| crc_en | input | 1 | Appends the checksum, sampled at start |
| tx_data | output | 8 | Byte to the serializer |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Serializer accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full 40-byte packet that streams through the 16-byte ring without underrunning or overflowing. The host must write one byte per cycle while the serializer drains one byte per cycle. The stimulus preloads eight bytes, writes start, and then issues the remaining 32 data writes back to back. This keeps the fill level between one and ten across the whole payload. The two fault paths are reached by starting with an empty ring, and by loading fewer bytes than the programmed length.

// File: rtl/pkt_tx_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the packet transmit sequencer.
package pkt_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SOP, ST_LEN, ST_PAY, ST_CRCH, ST_CRCL
    } tx_state_t;

    localparam logic [1:0] ADDR_LEN  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int FLG_NFULL = 5;
    localparam int FLG_HALF  = 4;
    localparam int FLG_EMPTY = 3;
    localparam int FLG_BERR  = 2;
    localparam int FLG_DONE  = 1;
    localparam int FLG_TXE   = 0;
endpackage

// File: rtl/tx_byte_ring.sv
`timescale 1ns/1ps
// Byte ring for payload, with a packet base pointer for resend.
// A write is accepted while the ring is not full, or while full with a
// pop in the same cycle. Clear wins over everything else. Rewind moves
// the read pointer back to the base; mark moves the base to the read pointer.
// Assumes rewind is only used when the stored packet fitted in the ring.
module tx_byte_ring #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          pop,
    input  logic          mark,
    input  logic          rewind,
    output logic [7:0]    head,
    output logic [PW-1:0] count
);
    localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr, base_ptr;
    logic          full, accept;

    assign count  = wr_ptr - rd_ptr;
    assign full   = (count == DEPTH_C);
    assign accept = wr_en && (!full || pop) && !clr;
    assign head   = mem[rd_ptr[AW-1:0]];

    // Store an accepted byte at the write slot.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    // Advance, clear, rewind and mark the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            base_ptr <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + 1'b1;
            if (rewind)   rd_ptr <= base_ptr;
            else if (pop) rd_ptr <= rd_ptr + 1'b1;
            if (mark)     base_ptr <= rd_ptr;
        end
    end

    // R7
    level_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
endmodule

// File: rtl/tx_crc16.sv
`timescale 1ns/1ps
// Bytewise checksum register, MSB first. init loads the seed; en folds
// din in. Assumes init and en are not asserted together.
module tx_crc16 #(
    parameter logic [15:0] POLY = 16'h1021,
    parameter logic [15:0] SEED = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    function automatic logic [15:0] fold(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ POLY;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    // Seed on start, fold each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || init) crc <= SEED;
        else if (en)        crc <= fold(crc, din);
    end

    // R3
    seed_on_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (crc == SEED));
endmodule

// File: rtl/tx_irq_regs.sv
`timescale 1ns/1ps
// Interrupt enables and sticky status flags. The two completion
// enables are written as a pair. A flag sets on its event and clears
// on a status read; a set in the same cycle wins.
module tx_irq_regs #(
    parameter int NFLAG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [NFLAG-1:0] en_wdata,
    input  logic             rd_clr,
    input  logic [NFLAG-1:0] evt,
    output logic [NFLAG-1:0] enable,
    output logic [NFLAG-1:0] status,
    output logic             irq
);
    logic pair;
    assign pair = en_wdata[1] | en_wdata[0];

    // Hold enables, forcing the completion pair to match.
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= NFLAG'(3);
        else if (en_wr) enable <= {en_wdata[NFLAG-1:2], pair, pair};
    end

    // Sticky flags with read-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~{NFLAG{rd_clr}}) | evt;
    end

    assign irq = |(status & enable);

    // R13
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));
endmodule

// File: rtl/pkt_tx_seq.sv
`timescale 1ns/1ps
// Packet transmit sequencer: host register port, payload ring, frame
// state machine (marker, length, payload, optional checksum) and
// interrupt flags. Assumes the serializer follows valid/ready, and that
// the host clears only while idle (clear is ignored while busy).
module pkt_tx_seq #(
    parameter int          DEPTH    = 16,
    parameter int          MAX_LEN  = 40,
    parameter logic [7:0]  SOP_BYTE = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr_en,
    input  logic       host_rd_en,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       crc_en,
    output logic [7:0] tx_data,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic       irq
);
    import pkt_tx_pkg::*;

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] DEPTH_C = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_C  = PW'(DEPTH / 2);

    tx_state_t     st, st_n;
    logic [7:0]    len_q, pkt_len, sent;
    logic          crc_on, resend_ok, busy, fire;
    logic          wr_len, wr_ctrl, wr_data, rd_stat, go, clr;
    logic          ev_berr, ev_txe, ev_done, sent_inc, pop, rewind, mark;
    logic [7:0]    head;
    logic [PW-1:0] buf_cnt;
    logic [15:0]   crc;
    logic [5:0]    enable, status, evt;

    // Host port decode.
    assign wr_len  = host_wr_en && (host_addr == ADDR_LEN);
    assign wr_ctrl = host_wr_en && (host_addr == ADDR_CTRL);
    assign wr_data = host_wr_en && (host_addr == ADDR_DATA);
    assign rd_stat = host_rd_en && (host_addr == ADDR_STAT);
    assign busy    = (st != ST_IDLE);
    assign go      = wr_ctrl && host_wdata[7] && !busy;
    assign clr     = wr_ctrl && host_wdata[6] && !busy;
    assign rewind  = go && (buf_cnt == '0) && resend_ok;
    assign mark    = go && (buf_cnt != '0);
    assign fire    = tx_valid && tx_ready;
    assign pop     = (st == ST_PAY) && fire;

    tx_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_data),
        .wr_data(host_wdata), .pop(pop), .mark(mark), .rewind(rewind),
        .head(head), .count(buf_cnt)
    );

    tx_crc16 u_crc (
        .clk(clk), .rst_n(rst_n), .init(go),
        .en(fire && (st == ST_LEN || st == ST_PAY)),
        .din(tx_data), .crc(crc)
    );

    // Event vector in status bit order.
    always_comb begin
        evt            = '0;
        evt[FLG_NFULL] = (buf_cnt < DEPTH_C);
        evt[FLG_HALF]  = (buf_cnt <= HALF_C);
        evt[FLG_EMPTY] = (buf_cnt == '0);
        evt[FLG_BERR]  = ev_berr;
        evt[FLG_DONE]  = ev_done;
        evt[FLG_TXE]   = ev_txe;
    end

    tx_irq_regs #(.NFLAG(6)) u_irq (
        .clk(clk), .rst_n(rst_n), .en_wr(wr_ctrl), .en_wdata(host_wdata[5:0]),
        .rd_clr(rd_stat), .evt(evt), .enable(enable), .status(status), .irq(irq)
    );

    // Length register, saturated at the largest packet.
    always_ff @(posedge clk) begin
        if (!rst_n)      len_q <= '0;
        else if (wr_len) len_q <= (host_wdata > 8'(MAX_LEN)) ? 8'(MAX_LEN) : host_wdata;
    end

    // Per-packet captures taken at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_len   <= '0;
            crc_on    <= 1'b0;
            resend_ok <= 1'b0;
        end else if (go) begin
            pkt_len   <= len_q;
            crc_on    <= crc_en;
            resend_ok <= (len_q <= 8'(DEPTH));
        end
    end

    // Payload byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || go) sent <= '0;
        else if (sent_inc) sent <= sent + 8'd1;
    end

    // Frame state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // Next frame state and end-of-packet events.
    always_comb begin
        st_n     = st;
        ev_berr  = 1'b0;
        ev_txe   = 1'b0;
        ev_done  = 1'b0;
        sent_inc = 1'b0;
        case (st)
            ST_IDLE: if (go) st_n = ST_SOP;
            ST_SOP:  if (fire) st_n = ST_LEN;
            ST_LEN: if (fire) begin
                if (pkt_len == 8'd0) begin
                    if (crc_on) st_n = ST_CRCH;
                    else begin st_n = ST_IDLE; ev_done = 1'b1; end
                end else if (buf_cnt == '0) begin
                    st_n = ST_IDLE; ev_berr = 1'b1;
                end else begin
                    st_n = ST_PAY;
                end
            end
            ST_PAY: begin
                if (buf_cnt == '0) begin
                    st_n = ST_IDLE; ev_txe = 1'b1;
                end else if (fire) begin
                    sent_inc = 1'b1;
                    if (sent + 8'd1 == pkt_len) begin
                        if (crc_on) st_n = ST_CRCH;
                        else begin st_n = ST_IDLE; ev_done = 1'b1; end
                    end
                end
            end
            ST_CRCH: if (fire) st_n = ST_CRCL;
            ST_CRCL: if (fire) begin st_n = ST_IDLE; ev_done = 1'b1; end
            default: st_n = ST_IDLE;
        endcase
    end

    // Outgoing byte and valid, selected by state.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        case (st)
            ST_SOP:  begin tx_valid = 1'b1; tx_data = SOP_BYTE; end
            ST_LEN:  begin tx_valid = 1'b1; tx_data = pkt_len; end
            ST_PAY:  begin tx_valid = (buf_cnt != '0); tx_data = head; end
            ST_CRCH: begin tx_valid = 1'b1; tx_data = crc[15:8]; end
            ST_CRCL: begin tx_valid = 1'b1; tx_data = crc[7:0]; end
            default: ;
        endcase
    end

    // Host read mux.
    always_comb begin
        case (host_addr)
            ADDR_LEN:  host_rdata = len_q;
            ADDR_CTRL: host_rdata = {busy, 1'b0, enable};
            ADDR_STAT: host_rdata = {2'b00, status};
            default:   host_rdata = 8'h00;
        endcase
    end

    // R5
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    // R5
    end_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(ev_done || ev_berr || ev_txe));
    // R8
    one_end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_berr, ev_txe, ev_done}));
    // R6
    hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/pkt_tx_seq_tb.sv
`timescale 1ns/1ps
module pkt_tx_seq_tb;
    localparam logic [1:0] A_LEN = 2'd0, A_CTRL = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       crc_en = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b1;
    logic       irq;
    logic       toggle_ready = 1'b0;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    pkt_tx_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .crc_en(crc_en), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .irq(irq)
    );

    // Record every accepted byte.
    always @(negedge clk) if (rst_n && tx_valid && tx_ready) got.push_back(tx_data);

    // Optional serializer stall pattern.
    always @(posedge clk) begin
        #1;
        if (toggle_ready) tx_ready = ~tx_ready;
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        host_rd_en = 1'b1; host_addr = a;
        @(negedge clk); d = host_rdata;
        @(posedge clk); #1;
        host_rd_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(A_CTRL, v);
            if (!v[7]) break;
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb = r[15] ^ b[i];
            r = r << 1;
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    // Build the expected frame for payload bytes base+0 .. base+n-1.
    task automatic build_exp(input int n, input logic [7:0] base, input bit with_crc);
        logic [15:0] c = 16'h0000;
        exp_q = {};
        exp_q.push_back(8'hA5);
        exp_q.push_back(8'(n));
        c = crc_step(c, 8'(n));
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(base + 8'(i));
            c = crc_step(c, base + 8'(i));
        end
        if (with_crc) begin
            exp_q.push_back(c[15:8]);
            exp_q.push_back(c[7:0]);
        end
    endtask

    task automatic check_frame(input string req);
        int bad = -1;
        check(req, "frame size", got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            if (bad < 0 && got[i] !== exp_q[i]) bad = i;
        if (bad >= 0) check(req, $sformatf("byte %0d", bad), got[bad], exp_q[bad]);
        else          check(req, "frame bytes", 0, 0);
    endtask

    task automatic load(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) wr(A_DATA, base + 8'(i));
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1", "irq", irq, 0);
        check("R1", "tx_valid", tx_valid, 0);
        rd(A_LEN, v);  check("R1", "length", v, 8'h00);
        rd(A_CTRL, v); check("R1", "control", v, 8'h03);
    endtask

    task automatic t_basic();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); rd(A_STAT, v);
        crc_en = 1'b0;
        wr(A_LEN, 8'd3); load(3, 8'h10);
        got = {};
        wr(A_CTRL, 8'h83);
        rd(A_CTRL, v); check("R5", "busy bit", v[7], 1);
        wait_idle();
        build_exp(3, 8'h10, 0); check_frame("R2");
        check("R5", "irq on complete", irq, 1);
        rd(A_STAT, v); check("R5", "complete flag", v[2:0], 3'b010);
        rd(A_STAT, v); check("R13", "flag cleared by read", v[1], 0);
        check("R12", "irq after clear", irq, 0);
    endtask

    task automatic t_resend();
        logic [7:0] v;
        got = {};
        wr(A_CTRL, 8'h83); wait_idle();
        build_exp(3, 8'h10, 0); check_frame("R11");
        rd(A_STAT, v);
    endtask

    task automatic t_crc_stall();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); wr(A_LEN, 8'd4); load(4, 8'h31);
        crc_en = 1'b1; got = {};
        toggle_ready = 1'b1;
        wr(A_CTRL, 8'h83); wait_idle();
        toggle_ready = 1'b0; tx_ready = 1'b1;
        build_exp(4, 8'h31, 1); check_frame("R3 R6");
        rd(A_STAT, v);
    endtask

    task automatic t_zero();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); wr(A_LEN, 8'd0);
        crc_en = 1'b1; got = {};
        wr(A_CTRL, 8'h83); wait_idle();
        build_exp(0, 8'h00, 1); check_frame("R4");
        rd(A_STAT, v); check("R4", "complete", v[1], 1);
    endtask

    task automatic t_berr();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); wr(A_LEN, 8'd2);
        crc_en = 1'b0; got = {};
        wr(A_CTRL, 8'h87); wait_idle();
        build_exp(0, 8'h00, 0); exp_q[1] = 8'd2; check_frame("R8");
        check("R8", "irq", irq, 1);
        rd(A_STAT, v); check("R8", "error flags", v[2:0], 3'b100);
        wr(A_CTRL, 8'h03);
    endtask

    task automatic t_underrun();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); wr(A_LEN, 8'd5); load(2, 8'h50);
        crc_en = 1'b1; got = {};
        wr(A_CTRL, 8'h83); wait_idle();
        build_exp(2, 8'h50, 0); exp_q[1] = 8'd5; check_frame("R9");
        check("R9", "irq", irq, 1);
        rd(A_STAT, v); check("R9", "error flags", v[2:0], 3'b001);
    endtask

    task automatic t_long();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); wr(A_LEN, 8'd40); load(8, 8'h00);
        crc_en = 1'b1; got = {};
        wr(A_CTRL, 8'h83);
        for (int i = 8; i < 40; i++) wr(A_DATA, 8'(i));
        wait_idle();
        build_exp(40, 8'h00, 1); check_frame("R7");
        rd(A_STAT, v); check("R7", "complete only", v[2:0], 3'b010);
        wr(A_LEN, 8'd100); rd(A_LEN, v); check("R7", "length saturates", v, 8'd40);
    endtask

    task automatic t_enables();
        logic [7:0] v;
        wr(A_CTRL, 8'h43);
        wr(A_CTRL, 8'h02); rd(A_CTRL, v); check("R12", "pair from bit1", v, 8'h03);
        wr(A_CTRL, 8'h01); rd(A_CTRL, v); check("R12", "pair from bit0", v, 8'h03);
        wr(A_CTRL, 8'h00); rd(A_CTRL, v); check("R12", "all off", v, 8'h00);
        wr(A_CTRL, 8'h08); @(negedge clk); check("R12", "irq from empty", irq, 1);
        @(posedge clk); #1;
        wr(A_CTRL, 8'h03); rd(A_STAT, v);
        @(negedge clk); check("R12", "irq masked", irq, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_levels_clear();
        logic [7:0] v;
        wr(A_CTRL, 8'h43); load(9, 8'h70);
        rd(A_STAT, v); rd(A_STAT, v); check("R13", "levels at 9", v[5:3], 3'b100);
        load(7, 8'h79);
        rd(A_STAT, v); rd(A_STAT, v); check("R13", "levels at 16", v[5:3], 3'b000);
        wr(A_CTRL, 8'h03);
        repeat (3) @(posedge clk); #1;
        check("R5", "zero start bit ignored", tx_valid, 0);
        rd(A_CTRL, v); check("R5", "still idle", v[7], 0);
        rd(A_STAT, v); rd(A_STAT, v); check("R10", "no clear on zero", v[3], 0);
        wr(A_CTRL, 8'h43);
        rd(A_STAT, v); rd(A_STAT, v); check("R10", "clear empties", v[5:3], 3'b111);
    endtask

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;
        t_reset();
        t_basic();
        t_resend();
        t_crc_stall();
        t_zero();
        t_berr();
        t_underrun();
        t_long();
        t_enables();
        t_levels_clear();
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule